// File: doc/BRIEF.md
# Logic, rotate and compare unit

An accumulator-side execution slice for an 8-bit datapath. Each cycle it takes the current accumulator, a second operand (from a register or an immediate field), the current flag set and a 4-bit operation code. When the valid strobe is high it registers a new accumulator value and a new five-bit flag set on the rising clock edge. When the strobe is low the registered outputs hold their values.

The unit covers bitwise AND, XOR and OR, a non-destructive compare, four one-position rotates (two circular, two through carry), accumulator complement, and the carry-only operations complement-carry and set-carry. Each operation has its own rule for which flags change. AND forces auxiliary carry high. Compare leaves the accumulator as it was. Rotates move only the carry. The three complement/set operations leave every flag they do not name untouched. Add and subtract, and any memory addressing, belong to other units.

Top module: `lrc_unit`

## Requirements
- R1: While `rst_n` is low, `acc_o` reads 0x00 and `flags_o` reads 0 from the next clock edge on.
- R2: `flags_o` and `flags_i` use this bit layout: bit 0 carry (CY), bit 1 parity (P), bit 2 auxiliary carry (AC), bit 3 zero (Z), bit 4 sign (S). The outputs change only on a rising edge with `valid_i` high, and they hold their values in every other cycle.
- R3: Op code 0 (AND) writes `acc_i & opnd_i`, clears CY and sets AC. S is bit 7 of the result, Z is set when the result is zero, and P is set when the result has an even number of one bits.
- R4: Op code 1 (XOR) and op code 2 (OR) write the corresponding bitwise result and clear both CY and AC. S, Z and P follow the result as in R3.
- R5: Op code 3 (compare) leaves the accumulator equal to `acc_i`. CY is set when `acc_i < opnd_i` (unsigned) and Z is set when the two are equal. S and P are taken from the 8-bit difference `acc_i - opnd_i`. AC is set when the low nibble of `acc_i` is below the low nibble of `opnd_i`.
- R6: Op code 4 rotates left so that bit 7 moves into both bit 0 and CY. Op code 5 rotates right so that bit 0 moves into both bit 7 and CY.
- R7: Op code 6 rotates left through carry: bit 7 goes to CY and the incoming CY goes to bit 0. Op code 7 rotates right through carry: bit 0 goes to CY and the incoming CY goes to bit 7.
- R8: The four rotates (op codes 4 to 7) copy S, Z, AC and P unchanged from `flags_i`.
- R9: Op code 8 writes `~acc_i` and copies all five flags unchanged from `flags_i`.
- R10: Op code 9 inverts CY and op code 10 sets CY. Both keep the accumulator and the other four flags as given at the inputs.
- R11: Op codes 11 to 15 are reserved. When one of them is strobed, `acc_i` and `flags_i` are copied to the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Strobe: register the result of this cycle |
| op_i | input | 4 | Operation code (see R3 to R11) |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand, register or immediate |
| flags_i | input | 5 | Current flags, layout as in R2 |
| acc_o | output | 8 | Registered accumulator result |
| flags_o | output | 5 | Registered flag result |

## Verification
The bench targets the cases where one flag policy could leak into another. An AND that copied the AC rule of XOR and OR would show AC low. A rotate that recomputed S, Z or P from its result would corrupt flags that are checked bit by bit. A compare that wrote the difference back would change the accumulator. Directed vectors cover compare at equal, below and above, including a borrow in the low nibble only. They also cover rotates of 0x80 and 0x01 with the carry in at both values, and an AND result of zero, where a design with inverted parity would clear P. Long random runs with the strobe sometimes low check that the outputs hold between updates and that the reserved codes pass both inputs through.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    localparam int FLG_W  = 5;
    localparam int FLG_CY = 0;
    localparam int FLG_P  = 1;
    localparam int FLG_AC = 2;
    localparam int FLG_Z  = 3;
    localparam int FLG_S  = 4;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'd0,
        OP_XOR = 4'd1,
        OP_OR  = 4'd2,
        OP_CMP = 4'd3,
        OP_RLC = 4'd4,
        OP_RRC = 4'd5,
        OP_RAL = 4'd6,
        OP_RAR = 4'd7,
        OP_CMA = 4'd8,
        OP_CMC = 4'd9,
        OP_STC = 4'd10
    } lrc_op_e;

endpackage

// File: rtl/lrc_bitwise.sv
module lrc_bitwise #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] and_o,
    output logic [DATA_W-1:0] xor_o,
    output logic [DATA_W-1:0] or_o
);
    always_comb begin
        and_o = a_i & b_i;
        xor_o = a_i ^ b_i;
        or_o  = a_i | b_i;
    end
endmodule

// File: rtl/lrc_compare.sv
module lrc_compare #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] diff_o,
    output logic              borrow_o,
    output logic              equal_o,
    output logic              half_borrow_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0]   wide_diff;
    logic [HALF_W:0]   low_diff;

    always_comb begin
        wide_diff     = {1'b0, a_i} - {1'b0, b_i};
        low_diff      = {1'b0, a_i[HALF_W-1:0]} - {1'b0, b_i[HALF_W-1:0]};
        diff_o        = wide_diff[DATA_W-1:0];
        borrow_o      = wide_diff[DATA_W];
        half_borrow_o = low_diff[HALF_W];
        equal_o       = (a_i == b_i);
    end
endmodule

// File: rtl/lrc_rotate.sv
module lrc_rotate #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] rlc_o,
    output logic [DATA_W-1:0] rrc_o,
    output logic [DATA_W-1:0] ral_o,
    output logic [DATA_W-1:0] rar_o
);
    localparam int TOP = DATA_W - 1;

    always_comb begin
        rlc_o = {a_i[TOP-1:0], a_i[TOP]};
        rrc_o = {a_i[0], a_i[TOP:1]};
        ral_o = {a_i[TOP-1:0], cin_i};
        rar_o = {cin_i, a_i[TOP:1]};
    end
endmodule

// File: rtl/lrc_unit.sv
module lrc_unit
    import lrc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [OP_W-1:0]      op_i,
    input  logic [DATA_W-1:0]    acc_i,
    input  logic [DATA_W-1:0]    opnd_i,
    input  logic [FLG_W-1:0]     flags_i,
    output logic [DATA_W-1:0]    acc_o,
    output logic [FLG_W-1:0]     flags_o
);
    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [FLG_W-1:0]  flg;
    } lrc_state_t;

    lrc_state_t st_d, st_q;

    logic [DATA_W-1:0] and_r, xor_r, or_r;
    logic [DATA_W-1:0] diff_r;
    logic              borrow_r, equal_r, half_borrow_r;
    logic [DATA_W-1:0] rlc_r, rrc_r, ral_r, rar_r;

    lrc_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .and_o (and_r),
        .xor_o (xor_r),
        .or_o  (or_r)
    );

    lrc_compare #(.DATA_W(DATA_W)) u_compare (
        .a_i           (acc_i),
        .b_i           (opnd_i),
        .diff_o        (diff_r),
        .borrow_o      (borrow_r),
        .equal_o       (equal_r),
        .half_borrow_o (half_borrow_r)
    );

    lrc_rotate #(.DATA_W(DATA_W)) u_rotate (
        .a_i   (acc_i),
        .cin_i (flags_i[FLG_CY]),
        .rlc_o (rlc_r),
        .rrc_o (rrc_r),
        .ral_o (ral_r),
        .rar_o (rar_r)
    );

    // Sign, zero and parity of a result; parity high for an even count of ones.
    function automatic logic [FLG_W-1:0] szp(input logic [DATA_W-1:0] v,
                                             input logic [FLG_W-1:0] base);
        logic [FLG_W-1:0] f;
        f         = base;
        f[FLG_S]  = v[MSB];
        f[FLG_Z]  = (v == '0);
        f[FLG_P]  = ~^v;
        return f;
    endfunction

    always_comb begin
        st_d.acc = acc_i;
        st_d.flg = flags_i;
        case (op_i)
            OP_AND: begin
                st_d.acc         = and_r;
                st_d.flg         = szp(and_r, flags_i);
                st_d.flg[FLG_AC] = 1'b1;
                st_d.flg[FLG_CY] = 1'b0;
            end
            OP_XOR: begin
                st_d.acc         = xor_r;
                st_d.flg         = szp(xor_r, flags_i);
                st_d.flg[FLG_AC] = 1'b0;
                st_d.flg[FLG_CY] = 1'b0;
            end
            OP_OR: begin
                st_d.acc         = or_r;
                st_d.flg         = szp(or_r, flags_i);
                st_d.flg[FLG_AC] = 1'b0;
                st_d.flg[FLG_CY] = 1'b0;
            end
            OP_CMP: begin
                st_d.flg         = szp(diff_r, flags_i);
                st_d.flg[FLG_Z]  = equal_r;
                st_d.flg[FLG_AC] = half_borrow_r;
                st_d.flg[FLG_CY] = borrow_r;
            end
            OP_RLC: begin
                st_d.acc         = rlc_r;
                st_d.flg[FLG_CY] = acc_i[MSB];
            end
            OP_RRC: begin
                st_d.acc         = rrc_r;
                st_d.flg[FLG_CY] = acc_i[0];
            end
            OP_RAL: begin
                st_d.acc         = ral_r;
                st_d.flg[FLG_CY] = acc_i[MSB];
            end
            OP_RAR: begin
                st_d.acc         = rar_r;
                st_d.flg[FLG_CY] = acc_i[0];
            end
            OP_CMA: begin
                st_d.acc = ~acc_i;
            end
            OP_CMC: begin
                st_d.flg[FLG_CY] = ~flags_i[FLG_CY];
            end
            OP_STC: begin
                st_d.flg[FLG_CY] = 1'b1;
            end
            default: begin
                st_d.acc = acc_i;
                st_d.flg = flags_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (valid_i) begin
            st_q <= st_d;
        end
    end

    assign acc_o   = st_q.acc;
    assign flags_o = st_q.flg;

endmodule

// File: rtl/lrc_chk.sv
module lrc_chk
    import lrc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 valid_i,
    input logic [OP_W-1:0]      op_i,
    input logic [DATA_W-1:0]    acc_i,
    input logic [DATA_W-1:0]    opnd_i,
    input logic [FLG_W-1:0]     flags_i,
    input logic [DATA_W-1:0]    acc_o,
    input logic [FLG_W-1:0]     flags_o
);
    localparam logic [FLG_W-1:0] KEEP_ROT = ~(FLG_W'(1) << FLG_CY);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0 && flags_o == '0));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(acc_o) && $stable(flags_o)));

    // R3
    and_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_AND) |=>
            (flags_o[FLG_AC] && !flags_o[FLG_CY] && flags_o[FLG_P] == ~^acc_o));

    // R4
    xor_or_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == OP_XOR || op_i == OP_OR)) |=>
            (!flags_o[FLG_AC] && !flags_o[FLG_CY] && flags_o[FLG_Z] == (acc_o == '0)));

    // R5
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_CMP) |=>
            (acc_o == $past(acc_i) &&
             flags_o[FLG_CY] == ($past(acc_i) < $past(opnd_i)) &&
             flags_o[FLG_Z] == ($past(acc_i) == $past(opnd_i))));

    // R8
    rot_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i >= OP_RLC && op_i <= OP_RAR) |=>
            ((flags_o & KEEP_ROT) == ($past(flags_i) & KEEP_ROT)));

    // R9
    cma_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_CMA) |=>
            (flags_o == $past(flags_i) && acc_o == ~$past(acc_i)));

    // R10
    stc_sets_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_STC) |=>
            (flags_o[FLG_CY] && acc_o == $past(acc_i)));
endmodule

bind lrc_unit lrc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .flags_i (flags_i),
    .acc_o   (acc_o),
    .flags_o (flags_o)
);

// File: tb/lrc_unit_tb.sv
`timescale 1ns/1ps
module lrc_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [4:0] flags_i = '0;
    logic [7:0] acc_o;
    logic [4:0] flags_o;

    int n_cmp = 0;
    int n_bad = 0;

    // expected registered state
    int exp_acc = 0;
    int exp_flg = 0;
    string exp_req = "R1";

    always #2 clk = ~clk;

    lrc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i),
        .acc_o(acc_o), .flags_o(flags_o)
    );

    function automatic int even_ones(input int v);
        int cnt = 0;
        for (int i = 0; i < 8; i++) if (((v >> i) & 1) != 0) cnt++;
        return (cnt % 2 == 0) ? 1 : 0;
    endfunction

    // flags packed as S Z AC P CY (bit 4 .. bit 0)
    function automatic int pack(input int s, input int z, input int ac, input int p, input int cy);
        return (s << 4) | (z << 3) | (ac << 2) | (p << 1) | cy;
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R3";
            1, 2: return "R4";
            3: return "R5";
            4, 5: return "R6 R8";
            6, 7: return "R7 R8";
            8: return "R9";
            9, 10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic model(input int op, input int a, input int b, input int f);
        int r, s, z, ac, p, cy;
        s = (f >> 4) & 1; z = (f >> 3) & 1; ac = (f >> 2) & 1; p = (f >> 1) & 1; cy = f & 1;
        r = a;
        case (op)
            0, 1, 2: begin
                if (op == 0) r = a & b; else if (op == 1) r = a ^ b; else r = a | b;
                s = (r >= 128) ? 1 : 0; z = (r == 0) ? 1 : 0; p = even_ones(r);
                ac = (op == 0) ? 1 : 0; cy = 0;
            end
            3: begin
                int d = (a - b + 256) % 256;
                s = (d >= 128) ? 1 : 0; p = even_ones(d);
                z = (a == b) ? 1 : 0; cy = (a < b) ? 1 : 0;
                ac = ((a % 16) < (b % 16)) ? 1 : 0;
            end
            4: begin cy = a / 128; r = ((a * 2) % 256) + cy; end
            5: begin cy = a % 2; r = (a / 2) + cy * 128; end
            6: begin r = ((a * 2) % 256) + cy; cy = a / 128; end
            7: begin r = (a / 2) + cy * 128; cy = a % 2; end
            8: r = 255 - a;
            9: cy = 1 - cy;
            10: cy = 1;
            default: ;
        endcase
        exp_acc = r;
        exp_flg = pack(s, z, ac, p, cy);
        exp_req = req_of(op);
    endtask

    task automatic compare_now();
        n_cmp++;
        if (int'(acc_o) != exp_acc || int'(flags_o) != exp_flg) begin
            n_bad++;
            $display("FAIL %s: acc=%02h flags=%05b expected acc=%02h flags=%05b",
                     exp_req, acc_o, flags_o, exp_acc[7:0], exp_flg[4:0]);
        end
    endtask

    // drive one cycle: inputs at negedge, compare at following negedge
    task automatic drive(input bit v, input int op, input int a, input int b, input int f);
        valid_i = v; op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flags_i = f[4:0];
        if (v) model(op, a, b, f);
        else exp_req = "R2";
        @(negedge clk);
        compare_now();
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, with garbage on the inputs and strobe high
        valid_i = 1'b1; op_i = 4'd8; acc_i = 8'h5a; flags_i = 5'h1f;
        repeat (3) @(negedge clk);
        exp_acc = 0; exp_flg = 0; exp_req = "R1";
        compare_now();
        rst_n = 1'b1;
        valid_i = 1'b0;
        @(negedge clk);
        compare_now();

        // R3: zero result from AND, even parity, AC forced high
        drive(1, 0, 'hf0, 'h0f, 'h01);
        drive(1, 0, 'hff, 'h81, 'h00);
        // R4
        drive(1, 1, 'ha5, 'ha5, 'h1f);
        drive(1, 2, 'h80, 'h01, 'h05);
        // R2: hold while idle even with new inputs
        drive(0, 8, 'h33, 'h00, 'h00);
        drive(0, 10, 'h00, 'h00, 'h00);
        // R5: equal, below, above, low-nibble borrow only
        drive(1, 3, 'h42, 'h42, 'h00);
        drive(1, 3, 'h10, 'h20, 'h00);
        drive(1, 3, 'h90, 'h10, 'h1f);
        drive(1, 3, 'h31, 'h0f, 'h00);
        // R6 R7 R8: rotates at the edge bits, both carry values
        drive(1, 4, 'h80, 0, 'h1e);
        drive(1, 5, 'h01, 0, 'h00);
        drive(1, 6, 'h80, 0, 'h00);
        drive(1, 6, 'h00, 0, 'h01);
        drive(1, 7, 'h01, 0, 'h1e);
        drive(1, 7, 'h00, 0, 'h01);
        // R9 R10 R11
        drive(1, 8, 'h3c, 'hff, 'h15);
        drive(1, 9, 'h77, 'h00, 'h0b);
        drive(1, 9, 'h77, 'h00, 'h0a);
        drive(1, 10, 'h12, 'h00, 'h1e);
        drive(1, 11, 'hc3, 'h99, 'h13);
        drive(1, 15, 'h3c, 'h99, 'h0c);

        // random sweep over all codes and strobe patterns
        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 4) != 0, $urandom % 16, $urandom % 256,
                  $urandom % 256, $urandom % 32);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule